// File: doc/BRIEF.md
# CPU Interrupt Delivery Unit

This block stands between the interrupt sources of a chip and a processor core. It collects three kinds of request: a reset request, a non-maskable interrupt (NMI) and a multi-bit maskable interrupt level. It keeps each one in its own pending register. It evaluates them only on instruction boundaries that the core signals with a single-cycle strobe. On each boundary it services at most one item, in fixed priority order. Reset and NMI share a single exception strobe toward the core. The maskable level is checked against the global interrupt enable and the interrupt-mask field that the core supplies from its status register.

The core keeps ownership of its architectural registers. When the block evaluates a level request or a clear, it drives a six-bit value for the hardware-interrupt-pending field of the core's cause register and pulses a write enable. A level request that is disabled or masked stays pending and is evaluated again at every later boundary until it is accepted or replaced. A level event carrying zero means "interrupt withdrawn". Its evaluation zeroes the cause field and returns the level path to idle without raising an exception.

Top module: `cpu_irq_deliver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outputs are zero: `exc_nmi_reset_o`, `exc_int_o`, `cause_ip_we_o` and `cause_ip_o`.
- R2: A pulse on `reset_req_i` is held pending. At the next boundary, `exc_nmi_reset_o` is high for exactly the cycle after that boundary, with no cause write, and the request is then consumed.
- R3: Priority per boundary is reset, then NMI, then the level path. Only one item is serviced per boundary. An NMI raises the same `exc_nmi_reset_o` strobe as a reset, and the two strobes are never high together.
- R4: When a boundary evaluates a pending nonzero level, `cause_ip_we_o` is high in the next cycle. `cause_ip_o` then equals the low six bits (bits 5..0) of the level.
- R5: A level is accepted when `status_ie_i` is 1 and the level's low six bits AND `status_im_i` is nonzero. `exc_int_o` then pulses in the same cycle as the cause write, and the level request is consumed.
- R6: A level that is not accepted stays pending. Every later boundary writes the cause field again with no `exc_int_o`, until the level is accepted or replaced.
- R7: A level event with value zero is a clear. The next boundary that reaches the level path writes zero to the cause field and raises no exception. Later boundaries write nothing.
- R8: A newer level event, clear or nonzero, replaces whatever level state is pending.
- R9: Without a boundary strobe, no output is ever asserted, whatever is pending.
- R10: A request event arriving in the same cycle as a boundary is not consumed by that boundary. It stays pending for the following boundary.
- R11: All three output strobes are single-cycle per boundary. Consecutive boundaries each produce their own evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Reset request event (one-cycle pulse) |
| nmi_req_i | input | 1 | Non-maskable interrupt event (one-cycle pulse) |
| lvl_evt_i | input | 1 | Maskable level event strobe |
| lvl_val_i | input | LVL_W (8) | Level value with the event; zero means clear |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| status_ie_i | input | 1 | Current global interrupt enable from status |
| status_im_i | input | IP_W (6) | Interrupt mask field from status |
| cause_ip_o | output | IP_W (6) | New value for the cause pending field |
| cause_ip_we_o | output | 1 | Write enable for the cause pending field |
| exc_nmi_reset_o | output | 1 | Combined reset/NMI exception strobe |
| exc_int_o | output | 1 | Maskable interrupt exception strobe |

## Verification
The hardest state to reach is a collision. In it, a new request event lands in the very cycle a boundary consumes an older item, so that the evaluation and the latch act on the same pending register at once. The stimulus builds this up deliberately. It first loads reset, NMI and a level together, then raises boundaries with fresh NMI and level events in those same cycles, and also replaces a masked level with a clear before the next boundary. A behavioural reference model tracks the pending items across all of this and is compared with the outputs on every clock.

// File: rtl/idu_pkg.sv
package idu_pkg;

    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_REQ  = 2'd1,
        LVL_CLR  = 2'd2
    } lvl_state_e;

    // Result of one boundary evaluation
    typedef struct packed {
        logic take_rst;
        logic take_nmi;
        logic take_clr;
        logic take_lvl;
        logic accept;
    } verdict_t;

endpackage

// File: rtl/idu_pend.sv
module idu_pend
    import idu_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_req_i,
    input  logic             nmi_req_i,
    input  logic             lvl_evt_i,
    input  logic [LVL_W-1:0] lvl_val_i,
    input  verdict_t         verdict_i,
    output logic             pend_rst_o,
    output logic             pend_nmi_o,
    output lvl_state_e       lvl_state_o,
    output logic [LVL_W-1:0] lvl_val_o
);

    typedef struct packed {
        logic             rst;
        logic             nmi;
        lvl_state_e       st;
        logic [LVL_W-1:0] val;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        // consumption by the current evaluation
        if (verdict_i.take_rst) pend_d.rst = 1'b0;
        if (verdict_i.take_nmi) pend_d.nmi = 1'b0;
        if (verdict_i.take_clr || verdict_i.accept) begin
            pend_d.st  = LVL_IDLE;
            pend_d.val = '0;
        end
        // new events win over consumption in the same cycle
        if (reset_req_i) pend_d.rst = 1'b1;
        if (nmi_req_i)   pend_d.nmi = 1'b1;
        if (lvl_evt_i) begin
            if (lvl_val_i == '0) begin
                pend_d.st  = LVL_CLR;
                pend_d.val = '0;
            end else begin
                pend_d.st  = LVL_REQ;
                pend_d.val = lvl_val_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '{rst: 1'b0, nmi: 1'b0, st: LVL_IDLE, val: '0};
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_rst_o  = pend_q.rst;
    assign pend_nmi_o  = pend_q.nmi;
    assign lvl_state_o = pend_q.st;
    assign lvl_val_o   = pend_q.val;

    assert_rst_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_i |=> pend_rst_o);

    assert_evt_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_i |=> pend_nmi_o);

    assert_clear_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_evt_i && lvl_val_i == '0) |=> (lvl_state_o == LVL_CLR));

endmodule

// File: rtl/idu_resolve.sv
module idu_resolve
    import idu_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int IP_W  = 6
) (
    input  logic             boundary_i,
    input  logic             pend_rst_i,
    input  logic             pend_nmi_i,
    input  lvl_state_e       lvl_state_i,
    input  logic [LVL_W-1:0] lvl_val_i,
    input  logic             status_ie_i,
    input  logic [IP_W-1:0]  status_im_i,
    output verdict_t         verdict_o,
    output logic [IP_W-1:0]  ip_val_o
);

    logic [IP_W-1:0] lvl_low;
    logic            unmasked;

    assign lvl_low  = lvl_val_i[IP_W-1:0];
    assign unmasked = status_ie_i && ((lvl_low & status_im_i) != '0);

    always_comb begin
        verdict_o = '0;
        ip_val_o  = '0;
        if (boundary_i) begin
            if (pend_rst_i) begin
                verdict_o.take_rst = 1'b1;
            end else if (pend_nmi_i) begin
                verdict_o.take_nmi = 1'b1;
            end else if (lvl_state_i == LVL_CLR) begin
                verdict_o.take_clr = 1'b1;
            end else if (lvl_state_i == LVL_REQ) begin
                verdict_o.take_lvl = 1'b1;
                ip_val_o           = lvl_low;
                verdict_o.accept   = unmasked;
            end
        end
    end

endmodule

// File: rtl/idu_out.sv
module idu_out
    import idu_pkg::*;
#(
    parameter int IP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary_i,
    input  verdict_t        verdict_i,
    input  logic [IP_W-1:0] ip_val_i,
    output logic            exc_nmi_reset_o,
    output logic            exc_int_o,
    output logic            cause_we_o,
    output logic [IP_W-1:0] cause_ip_o
);

    typedef struct packed {
        logic            nr;
        logic            intr;
        logic            we;
        logic [IP_W-1:0] ip;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = '0;
        out_d.nr   = verdict_i.take_rst | verdict_i.take_nmi;
        out_d.intr = verdict_i.accept;
        out_d.we   = verdict_i.take_clr | verdict_i.take_lvl;
        out_d.ip   = verdict_i.take_lvl ? ip_val_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign exc_nmi_reset_o = out_q.nr;
    assign exc_int_o       = out_q.intr;
    assign cause_we_o      = out_q.we;
    assign cause_ip_o      = out_q.ip;

    assert_single_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_nmi_reset_o && (exc_int_o || cause_we_o)));

    assert_int_with_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_int_o |-> (cause_we_o && cause_ip_o != '0));

    assert_needs_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_nmi_reset_o || exc_int_o || cause_we_o) |-> $past(boundary_i));

endmodule

// File: rtl/cpu_irq_deliver.sv
module cpu_irq_deliver
    import idu_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int IP_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_req_i,
    input  logic             nmi_req_i,
    input  logic             lvl_evt_i,
    input  logic [LVL_W-1:0] lvl_val_i,
    input  logic             boundary_i,
    input  logic             status_ie_i,
    input  logic [IP_W-1:0]  status_im_i,
    output logic [IP_W-1:0]  cause_ip_o,
    output logic             cause_ip_we_o,
    output logic             exc_nmi_reset_o,
    output logic             exc_int_o
);

    verdict_t         verdict;
    logic             pend_rst;
    logic             pend_nmi;
    lvl_state_e       lvl_state;
    logic [LVL_W-1:0] lvl_val;
    logic [IP_W-1:0]  ip_val;

    idu_pend #(.LVL_W(LVL_W)) pend_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_req_i (reset_req_i),
        .nmi_req_i   (nmi_req_i),
        .lvl_evt_i   (lvl_evt_i),
        .lvl_val_i   (lvl_val_i),
        .verdict_i   (verdict),
        .pend_rst_o  (pend_rst),
        .pend_nmi_o  (pend_nmi),
        .lvl_state_o (lvl_state),
        .lvl_val_o   (lvl_val)
    );

    idu_resolve #(.LVL_W(LVL_W), .IP_W(IP_W)) resolve_i (
        .boundary_i  (boundary_i),
        .pend_rst_i  (pend_rst),
        .pend_nmi_i  (pend_nmi),
        .lvl_state_i (lvl_state),
        .lvl_val_i   (lvl_val),
        .status_ie_i (status_ie_i),
        .status_im_i (status_im_i),
        .verdict_o   (verdict),
        .ip_val_o    (ip_val)
    );

    idu_out #(.IP_W(IP_W)) out_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .boundary_i      (boundary_i),
        .verdict_i       (verdict),
        .ip_val_i        (ip_val),
        .exc_nmi_reset_o (exc_nmi_reset_o),
        .exc_int_o       (exc_int_o),
        .cause_we_o      (cause_ip_we_o),
        .cause_ip_o      (cause_ip_o)
    );

    assert_clear_writes_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !pend_rst && !pend_nmi && lvl_state == LVL_CLR)
            |=> (cause_ip_we_o && cause_ip_o == '0 && !exc_int_o));

endmodule

// File: tb/cpu_irq_deliver_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_deliver_tb_top;

    localparam int LVL_W = 8;
    localparam int IP_W  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reset_req = 1'b0;
    logic             nmi_req = 1'b0;
    logic             lvl_evt = 1'b0;
    logic [LVL_W-1:0] lvl_val = '0;
    logic             boundary = 1'b0;
    logic             ie = 1'b0;
    logic [IP_W-1:0]  im = '0;
    logic [IP_W-1:0]  cause_ip;
    logic             cause_we;
    logic             exc_nr;
    logic             exc_int;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_rst = 0, m_nmi = 0, m_st = 0, m_val = 0; // m_st: 0 idle, 1 request, 2 clear
    int e_nr = 0, e_int = 0, e_we = 0, e_ip = 0;
    bit compare_on = 1'b0;

    always #2 clk = ~clk;

    cpu_irq_deliver #(.LVL_W(LVL_W), .IP_W(IP_W)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reset_req_i     (reset_req),
        .nmi_req_i       (nmi_req),
        .lvl_evt_i       (lvl_evt),
        .lvl_val_i       (lvl_val),
        .boundary_i      (boundary),
        .status_ie_i     (ie),
        .status_im_i     (im),
        .cause_ip_o      (cause_ip),
        .cause_ip_we_o   (cause_we),
        .exc_nmi_reset_o (exc_nr),
        .exc_int_o       (exc_int)
    );

    // behavioural model, evaluated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst = 0; m_nmi = 0; m_st = 0; m_val = 0;
            e_nr = 0; e_int = 0; e_we = 0; e_ip = 0;
        end else begin
            e_nr = 0; e_int = 0; e_we = 0; e_ip = 0;
            if (boundary) begin
                if (m_rst != 0) begin
                    m_rst = 0; e_nr = 1;
                end else if (m_nmi != 0) begin
                    m_nmi = 0; e_nr = 1;
                end else if (m_st == 2) begin
                    e_we = 1; e_ip = 0; m_st = 0;
                end else if (m_st == 1) begin
                    e_we = 1; e_ip = m_val % 64;
                    if (ie && ((e_ip & int'(im)) != 0)) begin
                        e_int = 1; m_st = 0;
                    end
                end
            end
            if (reset_req) m_rst = 1;
            if (nmi_req)   m_nmi = 1;
            if (lvl_evt) begin
                if (lvl_val == 0) m_st = 2;
                else begin m_st = 1; m_val = int'(lvl_val); end
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (compare_on) begin
            checks++;
            if (exc_nr !== 1'(e_nr) || exc_int !== 1'(e_int) ||
                cause_we !== 1'(e_we) || (cause_we && cause_ip !== IP_W'(e_ip))) begin
                errors++;
                $display("FAIL %s: actual nr=%0b int=%0b we=%0b ip=%0h expected nr=%0d int=%0d we=%0d ip=%0h",
                         tag, exc_nr, exc_int, cause_we, cause_ip, e_nr, e_int, e_we, e_ip);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reset_req = 1'b0; nmi_req = 1'b0; lvl_evt = 1'b0; boundary = 1'b0;
        end
    endtask

    task automatic drive(input bit r, input bit n, input bit le, input int lv, input bit b);
        @(negedge clk);
        reset_req = r; nmi_req = n; lvl_evt = le; lvl_val = LVL_W'(lv); boundary = b;
    endtask

    task automatic bnd();
        drive(0, 0, 0, 0, 1);
        idle(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs are zero in reset
        checks++;
        if (exc_nr !== 1'b0 || exc_int !== 1'b0 || cause_we !== 1'b0 || cause_ip !== '0) begin
            errors++;
            $display("FAIL R1: actual nr=%0b int=%0b we=%0b ip=%0h expected all zero",
                     exc_nr, exc_int, cause_we, cause_ip);
        end
        rst_n = 1'b1;
        compare_on = 1'b1;
        idle(2);

        // R9: pending items do nothing without a boundary
        tag = "R9"; ie = 1'b1; im = 6'h3f;
        drive(1, 1, 1, 3, 0);
        idle(10);

        // R3: reset first, then NMI, then level
        tag = "R3";
        bnd(); bnd(); bnd();

        // R2: lone reset request
        tag = "R2";
        drive(1, 0, 0, 0, 0); idle(3); bnd(); bnd();

        // R4 and R8: later level replaces earlier, upper bits dropped
        tag = "R8";
        drive(0, 0, 1, 9, 0); drive(0, 0, 1, 8'hc5, 0); idle(1);
        tag = "R4"; im = 6'h00;
        bnd();
        tag = "R5"; im = 6'h04;
        bnd(); bnd();

        // R6: masked and disabled levels keep retrying
        tag = "R6"; im = 6'h10; ie = 1'b1;
        drive(0, 0, 1, 6'h0a, 0); idle(1);
        bnd(); bnd(); bnd();
        ie = 1'b0; im = 6'h3f;
        bnd(); bnd();
        tag = "R5"; ie = 1'b1;
        bnd(); bnd();

        // R7: clear replaces masked level
        tag = "R7"; im = 6'h00;
        drive(0, 0, 1, 6'h21, 0); idle(1); bnd();
        drive(0, 0, 1, 0, 0); idle(1);
        bnd(); bnd(); bnd();

        // R10: events in the same cycle as a boundary survive it
        tag = "R10"; im = 6'h3f;
        drive(1, 0, 0, 0, 0);
        drive(0, 1, 1, 6'h02, 1);
        drive(0, 0, 0, 0, 1);
        drive(0, 0, 1, 6'h01, 1);
        drive(0, 0, 0, 0, 1);
        idle(3);

        // R11: back-to-back boundaries with masked level
        tag = "R11"; im = 6'h00;
        drive(0, 0, 1, 6'h30, 0);
        for (int k = 0; k < 6; k++) drive(0, 0, 0, 0, 1);
        im = 6'h20;
        drive(0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 1);
        idle(4);

        compare_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule